// File: doc/BRIEF.md
# Clock Level Best-Match Search Unit

This block picks, from a table of available source clock frequencies, the entry that best serves a requested output frequency when the source is divided by a whole number. For every table entry it derives the divider as the ceiling of entry over request. It then takes the resulting output, entry divided by that divider and rounded down, which never exceeds the request. The undershoot is the request minus that output. The entry with the smallest undershoot wins, and on equal undershoot the lower index wins.

The table is written through a simple write port while the unit is idle. A search starts with a one-cycle `start` pulse and walks the table one entry at a time. Each entry is reduced by a shared multi-cycle restoring divider. The walk ends early on an exact hit, where the undershoot is zero. Otherwise it ends at the first entry that is zero or that repeats its predecessor, or after the last slot. A one-cycle `done` pulse reports the outcome together with the winning index and frequency. In exact mode, the search fails unless some entry divides to exactly the request.

Top module: `clk_level_match`

## Requirements
- R1: After reset, `done`, `busy` and `ok` are 0, `match_idx` and `match_freq` are 0, and every table slot holds 0, so a search fails.
- R2: For each walked entry f and request r, the divider is d = ceil(f / r) and the undershoot is r - floor(f / d). On success, `match_idx` and `match_freq` give the entry with the smallest undershoot.
- R3: A later entry replaces the current best only when its undershoot is strictly smaller. Equal undershoots keep the lower index.
- R4: An entry with zero undershoot ends the search at once with `ok` = 1. The result for a hit at index k appears no later than (k+1)*(2*(W+1)+2) cycles after the cycle in which `start` is taken.
- R5: With `exact` = 1, a search that finds no entry with zero undershoot reports `ok` = 0. With `exact` = 0, it reports `ok` = 1 with the closest entry.
- R6: The walk stops before the first slot that holds 0 or that equals the slot before it. Neither that slot nor any later slot can win.
- R7: A table whose slot 0 holds 0 is empty, and a search on it reports `ok` = 0.
- R8: A request of 0 is rejected without a walk. `done` = 1 and `ok` = 0 appear in the cycle after `start`, and `busy` stays 0.
- R9: `done` is high for exactly one cycle per search. Whenever `done` = 1 and `ok` = 0, `match_idx` and `match_freq` are 0.
- R10: While `busy` = 1, `start` and table writes are ignored. The running search completes on the values it began with, and the table keeps its contents.
- R11: When no slot stops the walk early, all DEPTH slots are considered, including the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table slot (idle only) |
| wr_addr | input | clog2(DEPTH) | Slot to write |
| wr_data | input | W | Frequency value written |
| start | input | 1 | Begin a search (idle only) |
| req_freq | input | W | Requested output frequency |
| exact | input | 1 | Require a zero-undershoot match |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Search succeeded |
| match_idx | output | clog2(DEPTH) | Winning slot index |
| match_freq | output | W | Winning slot frequency |

## Verification
The bench sweeps many requests against tables that are full, cut short by a repeat, cut short by a zero, and empty, in both modes. Each result is compared with an arithmetic model. A divider rounding down instead of up would pick outputs above the request, and a non-strict compare would let an equal later entry steal a tie. Walking past a repeated or zero slot would let a hidden entry win, and ignoring the last slot would lose full-table winners. Separate cases cover a zero request, the early exit latency on exact hits, and a start and a table write issued mid-search, which a careless design would act on.

// File: rtl/clk_level_match.sv
module clk_level_match #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] wr_addr,
  input  logic [W-1:0]                         wr_data,
  input  logic                                 start,
  input  logic [W-1:0]                         req_freq,
  input  logic                                 exact,
  output logic                                 busy,
  output logic                                 done,
  output logic                                 ok,
  output logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] match_idx,
  output logic [W-1:0]                         match_freq
);
  localparam int N  = W + 1;
  localparam int IW = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(N + 1);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_DIV1, S_DIV2, S_EVAL} st_t;
  st_t st;

  logic [W-1:0]  tbl [DEPTH];
  logic [IW:0]   idx;
  logic [W-1:0]  req_q, best_err, best_f;
  logic [IW-1:0] best_idx;
  logic          exact_q, found;
  logic [N-1:0]  dvd, dvs, rem;
  logic [CW-1:0] cnt;

  wire [IW-1:0] ia  = (idx < (IW+1)'(DEPTH)) ? idx[IW-1:0] : '0;
  wire [W-1:0]  cur = tbl[ia];
  wire [W-1:0]  prv = tbl[(ia == '0) ? ia : ia - 1'b1];
  wire          stop = (idx == (IW+1)'(DEPTH)) || (cur == '0) || (idx != '0 && cur == prv);

  wire [N:0]    sh = {rem, dvd[N-1]};
  wire [N:0]    tr = sh - {1'b0, dvs};
  wire          ge = ~tr[N];
  wire [N-1:0]  qn = {dvd[N-2:0], ge};
  wire [N-1:0]  rn = ge ? tr[N-1:0] : sh[N-1:0];
  wire          last = (cnt == CW'(N - 1));
  wire [W-1:0]  err = req_q - dvd[W-1:0];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (wr_en && st == S_IDLE && int'(wr_addr) < DEPTH) begin
      tbl[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; req_q <= '0; exact_q <= 1'b0;
      best_err <= '0; best_f <= '0; best_idx <= '0; found <= 1'b0;
      dvd <= '0; dvs <= '0; rem <= '0; cnt <= '0;
      done <= 1'b0; ok <= 1'b0; match_idx <= '0; match_freq <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (req_freq == '0) begin
            done <= 1'b1; ok <= 1'b0; match_idx <= '0; match_freq <= '0;
          end else begin
            req_q <= req_freq; exact_q <= exact; idx <= '0;
            best_err <= '1; found <= 1'b0; st <= S_CHECK;
          end
        end
        S_CHECK: if (stop) begin
          done       <= 1'b1;
          ok         <= found && !exact_q;
          match_idx  <= (found && !exact_q) ? best_idx : '0;
          match_freq <= (found && !exact_q) ? best_f : '0;
          st         <= S_IDLE;
        end else begin
          dvd <= N'(cur) + N'(req_q) - 1'b1;
          dvs <= N'(req_q);
          rem <= '0; cnt <= '0; st <= S_DIV1;
        end
        S_DIV1: begin
          rem <= rn; dvd <= qn; cnt <= cnt + 1'b1;
          if (last) begin
            dvd <= N'(cur); dvs <= qn; rem <= '0; cnt <= '0; st <= S_DIV2;
          end
        end
        S_DIV2: begin
          rem <= rn; dvd <= qn; cnt <= cnt + 1'b1;
          if (last) st <= S_EVAL;
        end
        S_EVAL: begin
          if (err < best_err) begin
            best_err <= err; best_idx <= ia; best_f <= cur; found <= 1'b1;
          end
          if (err == '0) begin
            done <= 1'b1; ok <= 1'b1; match_idx <= ia; match_freq <= cur;
            st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1; st <= S_CHECK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_level_match_chk.sv
module clk_level_match_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 start,
  input logic [W-1:0]                         req_freq,
  input logic                                 busy,
  input logic                                 done,
  input logic                                 ok,
  input logic [(DEPTH>1?$clog2(DEPTH):1)-1:0] match_idx,
  input logic [W-1:0]                         match_freq
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (match_idx == '0 && match_freq == '0));
  assert_zero_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_freq == '0) |=> (done && !ok && !busy));
  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_ok_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (match_freq != '0));
endmodule

bind clk_level_match clk_level_match_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .req_freq(req_freq), .busy(busy),
  .done(done), .ok(ok), .match_idx(match_idx), .match_freq(match_freq));

// File: tb/clk_level_match_tb_top.sv
`timescale 1ns/1ps
module clk_level_match_tb_top;
  localparam int W = 16, DEPTH = 8, IW = 3, N = W + 1, STEP = 2 * N + 2;

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0, exact = 0;
  logic [IW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0, req_freq = '0;
  logic busy, done, ok;
  logic [IW-1:0] match_idx;
  logic [W-1:0] match_freq;

  int n_chk = 0, n_fail = 0, cycles = 0;
  longint tb [DEPTH];

  always #5 clk = ~clk;

  clk_level_match #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .req_freq(req_freq), .exact(exact), .busy(busy), .done(done),
    .ok(ok), .match_idx(match_idx), .match_freq(match_freq));

  task automatic chk(input bit c, input string r, input longint act, input longint exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic load(input longint v [DEPTH]);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); wr_en = 1; wr_addr = IW'(i); wr_data = W'(v[i]); tb[i] = v[i];
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic model(input longint r, input bit ex, output bit eok, output longint ei,
                       output longint ef, output longint hit);
    longint best = 64'h7fffffffffffffff, d, e;
    bit fnd = 0;
    eok = 0; ei = 0; ef = 0; hit = -1;
    if (r == 0) return;
    for (int i = 0; i < DEPTH; i++) begin
      if (tb[i] == 0 || (i > 0 && tb[i] == tb[i-1])) break;
      d = (tb[i] + r - 1) / r;
      e = r - tb[i] / d;
      if (e < best) begin
        best = e; fnd = 1; ei = i; ef = tb[i];
        if (e == 0) begin eok = 1; hit = i; return; end
      end
    end
    if (!fnd || ex) begin ei = 0; ef = 0; eok = 0; end else eok = 1;
  endtask

  task automatic run(input longint r, input bit ex);
    @(negedge clk); start = 1; req_freq = W'(r); exact = ex;
    @(negedge clk); start = 0; cycles = 1;
    while (!done && cycles < 5000) begin @(negedge clk); cycles++; end
  endtask

  task automatic search(input longint r, input bit ex, input string tag);
    bit eok; longint ei, ef, hit;
    model(r, ex, eok, ei, ef, hit);
    run(r, ex);
    chk(done == 1, tag, done, 1);
    chk(ok == eok, tag, ok, eok);
    chk(match_idx == ei, tag, match_idx, ei);
    chk(match_freq == ef, tag, match_freq, ef);
    if (hit >= 0) chk(cycles <= (hit + 1) * STEP + 1, "R4 latency", cycles, (hit + 1) * STEP);
    @(negedge clk);
    chk(done == 0, "R9 pulse", done, 0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint t0 [DEPTH] = '{7372, 14745, 19200, 29491, 32000, 48000, 50000, 64000};
    longint t1 [DEPTH] = '{100, 200, 200, 400, 800, 1600, 3200, 6400};
    longint t2 [DEPTH] = '{60, 90, 0, 400, 800, 1000, 2000, 4000};
    longint t3 [DEPTH] = '{1000, 3000, 7000, 9000, 11000, 13000, 0, 0};
    for (int i = 0; i < DEPTH; i++) tb[i] = 0;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !ok && match_idx == 0 && match_freq == 0, "R1 reset", done, 0);
    rst_n = 1;
    search(1000, 0, "R1 R7 empty after reset");
    search(0, 0, "R8 zero request");
    chk(cycles == 1, "R8 latency", cycles, 1);

    load(t0);
    for (int i = 0; i < 30; i++) begin
      search(1 + (i * i * 97 + i * 13) % 40000, 0, "R2 R11 full sweep");
      search(1 + (i * i * 97 + i * 13) % 40000, 1, "R5 full exact sweep");
    end
    search(64000, 1, "R11 last slot exact");
    search(32000, 1, "R4 R5 exact hit");
    search(16000, 0, "R4 exact hit via divider");

    load(t1);
    search(400, 0, "R6 repeat stops walk");
    search(400, 1, "R6 R5 repeat exact fail");
    for (int i = 1; i < 20; i++) search(i * 23, i[0], "R2 R6 repeat sweep");

    load(t2);
    search(40, 0, "R3 tie keeps lower index");
    search(400, 1, "R6 zero stops walk");
    for (int i = 1; i < 20; i++) search(i * 7, i[0], "R3 R6 zero sweep");

    load(t3);
    for (int i = 1; i < 25; i++) search(i * 457, i[1], "R2 R5 partial sweep");

    @(negedge clk); start = 1; req_freq = 3000; exact = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(busy == 1, "R10 busy", busy, 1);
    start = 1; req_freq = 7000; wr_en = 1; wr_addr = 1; wr_data = 2999;
    @(negedge clk); start = 0; wr_en = 0; cycles = 12;
    while (!done && cycles < 5000) begin @(negedge clk); cycles++; end
    chk(ok == 1 && match_idx == 1, "R10 start ignored idx", match_idx, 1);
    chk(match_freq == 3000, "R10 start ignored freq", match_freq, 3000);
    search(3000, 1, "R10 write ignored");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule